// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block turns a fast input clock into a repeating train of four phases, Q1 through Q4, one phase per input clock. Four phases make up one instruction cycle. On that frame the block runs a two-stage pipeline in which fetch and execute overlap. A program counter supplies the fetch address to program memory. The returned word is captured at the boundary between cycles into an instruction register, and the execute logic outside the block works on it during the next cycle.

The block gives that execute logic an operand-read strobe in Q2 and a destination-write strobe in Q4. It also provides a divided clock at one quarter of the input rate. Execute can report a taken branch together with a target address. The sequencer then loads the target in place of the normal increment and discards the word it already prefetched. A no-operation takes the place of that word for one cycle, so a branch costs two instruction cycles in total. Decoding, the ALU and the register file belong to the surrounding design.

Top module: `qcycle_sequencer`

## Requirements
- R1: `phase_oh` is one-hot, with bit 0 meaning Q1 up to bit 3 meaning Q4. It advances by one phase on each rising clock edge, Q1→Q2→Q3→Q4→Q1.
- R2: `clk_out` is 1 during Q1 and Q2 and 0 during Q3 and Q4.
- R3: While `rst` is high at a rising edge, the phase becomes Q1, `fetch_addr` becomes 0 and `ir` becomes the no-operation word (parameter `NOP_WORD`, default all zeros). Neither strobe is active.
- R4: `fetch_addr` is constant inside an instruction cycle. At the edge that ends Q4 it increases by 1 modulo 2^PC_W, so it wraps from all ones to 0.
- R5: The value on `imem_data` at the edge that ends Q4 is loaded into `ir`, and `ir` holds it for the whole next cycle. The word at address 0 is therefore executed in the second cycle after reset.
- R6: When `ir` holds a valid word, `rd_stb` is high only in Q2 of the cycle and `wr_stb` only in Q4. Both stay low in a no-operation cycle inserted by reset or by a flush.
- R7: `br_taken` is sampled at the edge that ends Q4 of a cycle with a valid word. If it is high, `br_target` is loaded into the program counter instead of the increment.
- R8: After a taken branch, `ir` holds `NOP_WORD` for one cycle with no strobes. The word at the target address is executed in the cycle after that.
- R9: `br_taken` during a no-operation cycle is ignored, and the program counter increments normally.
- R10: `br_taken` that is high during Q1–Q3 but low at the edge that ends Q4 has no effect on the program counter or on `ir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| imem_data | input | IW_W | Word returned by program memory for `fetch_addr` |
| br_taken | input | 1 | Execute reports that a branch is taken |
| br_target | input | PC_W | Branch destination address |
| fetch_addr | output | PC_W | Program memory address (program counter) |
| ir | output | IW_W | Instruction register |
| phase_oh | output | 4 | One-hot current phase, bit 0 = Q1 |
| rd_stb | output | 1 | Operand-read strobe (Q2 of a valid cycle) |
| wr_stb | output | 1 | Destination-write strobe (Q4 of a valid cycle) |
| clk_out | output | 1 | Clock divided by four, high in Q1 and Q2 |

## Verification
The bench builds the block with PC_W = 4 and IW_W = 14. With that counter width, wraparound of the program counter is reached after sixteen cycles, both by plain increments and by a branch to the top address. The bench models program memory as an address-derived function that never returns the no-operation word, so every flushed slot can be told apart from a fetched one. The sequences it drives include back-to-back branches, a branch request during a bubble, a branch pulse that drops before Q4 ends, and a reset in the middle of a run.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;

  localparam int unsigned NUM_PHASES = 4;

  // Phase that follows p in the four-phase ring.
  function automatic qphase_e next_phase(input qphase_e p);
    return qphase_e'(2'(p) + 2'd1);
  endfunction

  // Divided clock level for a given phase: high in the first half.
  function automatic logic half_high(input qphase_e p);
    return (p == PH_Q1) || (p == PH_Q2);
  endfunction

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output qphase_e    ph,
  output logic [3:0] ph_oh,
  output logic       cyc_end,
  output logic       clk_div
);

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_Q1;
    else     ph <= next_phase(ph);
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_oh
    assign ph_oh[i] = (ph == qphase_e'(2'(i)));
  end

  assign cyc_end = (ph == PH_Q4);
  assign clk_div = half_high(ph);

  // R1: the ring closes from Q4 back to Q1
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_Q4) |=> (ph == PH_Q1));

  // R1: Q1 is always followed by Q2
  a_r1_phase_q1_q2: assert property (@(posedge clk) disable iff (rst)
    ph_oh[0] |=> ph_oh[1]);

  // R2: the divided clock falls only on entry to Q3
  a_r2_clk_div_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_div) |-> ph_oh[2]);

endmodule

// File: rtl/qseq_pc.sv
module qseq_pc #(
  parameter int unsigned PC_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_end,
  input  logic            take_br,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] PC_TOP = '1;

  // Increment modulo 2^PC_W.
  function automatic logic [PC_W-1:0] pc_inc(input logic [PC_W-1:0] v);
    return v + PC_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (cyc_end) pc <= take_br ? target : pc_inc(pc);
  end

  // R4: address holds within an instruction cycle
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(pc));

  // R4: top address wraps to zero
  a_r4_pc_wrap: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !take_br && pc == PC_TOP) |=> (pc == '0));

  // R7: a taken branch loads the target
  a_r7_branch_load: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && take_br) |=> (pc == $past(target)));

endmodule

// File: rtl/qseq_ir.sv
module qseq_ir #(
  parameter int unsigned    IW_W     = 14,
  parameter logic [IW_W-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_end,
  input  logic            take_br,
  input  logic [IW_W-1:0] word_in,
  output logic [IW_W-1:0] ir,
  output logic            bubble
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir     <= NOP_WORD;
      bubble <= 1'b1;
    end else if (cyc_end) begin
      if (take_br) begin
        ir     <= NOP_WORD;
        bubble <= 1'b1;
      end else begin
        ir     <= word_in;
        bubble <= 1'b0;
      end
    end
  end

  // R8: a flush leaves a no-operation in the register
  a_r8_flush_nop: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && take_br) |=> (bubble && ir == NOP_WORD));

  // R5: register is stable inside a cycle
  a_r5_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(ir));

  // R5: a fetched word lands in the register
  a_r5_ir_capture: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !take_br) |=> (ir == $past(word_in)));

endmodule

// File: rtl/qcycle_sequencer.sv
module qcycle_sequencer
  import qseq_pkg::*;
#(
  parameter int unsigned     PC_W     = 11,
  parameter int unsigned     IW_W     = 14,
  parameter logic [IW_W-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW_W-1:0] imem_data,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] fetch_addr,
  output logic [IW_W-1:0] ir,
  output logic [3:0]      phase_oh,
  output logic            rd_stb,
  output logic            wr_stb,
  output logic            clk_out
);

  qphase_e ph;
  logic    cyc_end;
  logic    bubble;
  logic    exec_valid;
  logic    take_br;

  qseq_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .ph_oh   (phase_oh),
    .cyc_end (cyc_end),
    .clk_div (clk_out)
  );

  // Branch requests count only for a real instruction in execute.
  assign exec_valid = !bubble;
  assign take_br    = br_taken && exec_valid;

  qseq_pc #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .take_br (take_br),
    .target  (br_target),
    .pc      (fetch_addr)
  );

  qseq_ir #(.IW_W(IW_W), .NOP_WORD(NOP_WORD)) u_ir (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .take_br (take_br),
    .word_in (imem_data),
    .ir      (ir),
    .bubble  (bubble)
  );

  assign rd_stb = exec_valid && (ph == PH_Q2);
  assign wr_stb = exec_valid && (ph == PH_Q4);

  // R6: operand read fires only in Q2
  a_r6_rd_in_q2: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (phase_oh == 4'b0010));

  // R6: every write is preceded by a read of the same cycle
  a_r6_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(rd_stb, 2));

  // R9: a branch request in a bubble does not flush again
  a_r9_bubble_ignores_branch: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && bubble && br_taken) |=> exec_valid);

  // R3: reset leaves the register at no-operation
  a_r3_reset_nop: assert property (@(posedge clk)
    rst |=> (ir == NOP_WORD && fetch_addr == '0 && !rd_stb && !wr_stb));

endmodule

// File: tb/qcycle_sequencer_tb.sv
module qcycle_sequencer_tb;

  localparam int unsigned PC_W = 4;
  localparam int unsigned IW_W = 14;
  localparam logic [IW_W-1:0] NOP = '0;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [IW_W-1:0] imem_data;
  logic            br_taken = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [PC_W-1:0] fetch_addr;
  logic [IW_W-1:0] ir;
  logic [3:0]      phase_oh;
  logic            rd_stb, wr_stb, clk_out;

  always #2.5 clk = ~clk;

  qcycle_sequencer #(.PC_W(PC_W), .IW_W(IW_W), .NOP_WORD(NOP)) u_dut (
    .clk(clk), .rst(rst), .imem_data(imem_data), .br_taken(br_taken),
    .br_target(br_target), .fetch_addr(fetch_addr), .ir(ir),
    .phase_oh(phase_oh), .rd_stb(rd_stb), .wr_stb(wr_stb), .clk_out(clk_out)
  );

  // Program memory model: never yields the no-operation word.
  function automatic logic [IW_W-1:0] mem_word(input logic [PC_W-1:0] a);
    return 14'h2000 | 14'(32'(a) * 13 + 5);
  endfunction
  assign imem_data = mem_word(fetch_addr);

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [IW_W-1:0] word;
    logic            bub;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // Bench phase count, 0 = Q1
  logic [1:0] bph = 2'd0;
  always @(posedge clk) bph <= rst ? 2'd0 : bph + 2'd1;

  // Monitor
  exp_t  cur;
  string cur_tag;
  bit    cur_ok = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 phase", 32'(phase_oh), 32'(4'b0001 << bph));
      chk("R2 clk_out", 32'(clk_out), 32'(bph < 2'd2));
      if (bph == 2'd1 && sb_q.size() > 0) begin
        cur     = sb_q.pop_front();
        cur_tag = tag_q.pop_front();
        cur_ok  = 1;
        chk({cur_tag, " R4 fetch_addr"}, 32'(fetch_addr), 32'(cur.pc));
        chk({cur_tag, " R5/R8 ir"}, 32'(ir), 32'(cur.word));
        chk({cur_tag, " R6 rd_stb"}, 32'(rd_stb), 32'(!cur.bub));
      end
      if (bph == 2'd3 && cur_ok) begin
        chk({cur_tag, " R6 wr_stb"}, 32'(wr_stb), 32'(!cur.bub));
        chk({cur_tag, " R6 rd_stb off"}, 32'(rd_stb), 32'(0));
      end
    end
  end

  // Reference model
  logic [PC_W-1:0] m_pc;
  logic [IW_W-1:0] m_ir;
  logic            m_bub;

  // Driver: one instruction cycle, starting at a Q1 negedge.
  task automatic run_cyc(input string tag, input bit bt, input logic [PC_W-1:0] tgt,
                         input bit pulse_only);
    bit eff;
    sb_q.push_back('{pc: m_pc, word: m_ir, bub: m_bub});
    tag_q.push_back(tag);
    br_taken  = bt;
    br_target = tgt;
    if (pulse_only) begin
      repeat (3) @(negedge clk);
      br_taken = 1'b0;
      @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
    eff = bt && !pulse_only && !m_bub;
    if (eff) begin
      m_ir  = NOP;
      m_bub = 1'b1;
      m_pc  = tgt;
    end else begin
      m_ir  = mem_word(m_pc);
      m_bub = 1'b0;
      m_pc  = m_pc + PC_W'(1);
    end
  endtask

  task automatic do_reset();
    br_taken = 1'b0;
    rst = 1'b1;
    cur_ok = 0;
    repeat (3) @(negedge clk);
    chk("R3 fetch_addr", 32'(fetch_addr), 32'(0));
    chk("R3 ir", 32'(ir), 32'(NOP));
    chk("R3 phase", 32'(phase_oh), 32'(4'b0001));
    chk("R3 strobes", 32'({rd_stb, wr_stb}), 32'(0));
    m_pc = '0; m_ir = NOP; m_bub = 1'b1;
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R5: straight-line run, including wrap of the counter (R4)
    for (int k = 0; k < 20; k++) run_cyc("R4 seq", 1'b0, '0, 1'b0);
    // R7: taken branch, then R9: request in the bubble is ignored
    run_cyc("R7 br", 1'b1, 4'd5, 1'b0);
    run_cyc("R9 bubble", 1'b1, 4'd9, 1'b0);
    run_cyc("R8 target", 1'b0, '0, 1'b0);
    run_cyc("R8 next", 1'b0, '0, 1'b0);
    // R10: pulse that drops before the end of Q4
    run_cyc("R10 pulse", 1'b1, 4'd12, 1'b1);
    run_cyc("R10 after", 1'b0, '0, 1'b0);
    // R7: branch to top address, then wrap (R4)
    run_cyc("R7 top", 1'b1, 4'd15, 1'b0);
    for (int k = 0; k < 4; k++) run_cyc("R4 wrap", 1'b0, '0, 1'b0);
    // R8: back-to-back branches on each valid word
    for (int k = 0; k < 6; k++) run_cyc("R8 b2b", 1'b1, PC_W'(k * 3), 1'b0);
    run_cyc("R8 tail", 1'b0, '0, 1'b0);
    run_cyc("R8 tail", 1'b0, '0, 1'b0);
    // R3: reset mid-run
    do_reset();
    run_cyc("R3 first", 1'b1, 4'd7, 1'b0);
    for (int k = 0; k < 4; k++) run_cyc("R5 restart", 1'b0, '0, 1'b0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule